// File: doc/BRIEF.md
# Program and graphics bank mapper

This block turns CPU and graphics-bus addresses into physical ROM addresses for a cartridge that switches banks. Four 5-bit configuration registers drive it: a control register, a low and a high graphics register, and a program register. From these it selects 16 KB program banks for the CPU window at 0x8000–0xFFFF and 4 KB graphics banks for the 8 KB graphics window. It also reports the nametable mirroring arrangement and enables work RAM at 0x6000–0x7FFF. The logic that loads the registers serially is outside this block. The registers are plain inputs here.

All outputs are computed combinationally from the current inputs and captured in one register stage. Each result therefore appears one clock after its inputs. The program mapping has three arrangements: one 32 KB window, 16 KB with the upper slot fixed, and 16 KB with the lower slot fixed. Bit 4 of the low graphics register acts as an outer offset on every program bank, for boards with 512 KB of program ROM. Bank numbers beyond the fitted ROM wrap modulo the bank counts given as parameters.

Top module: `bank_mapper`

## Requirements
- R1: `mirror_mode` equals control bits 1:0, with these codes: 0 is single screen A, 1 is single screen B, 2 is vertical and 3 is horizontal.
- R2: With control bit 3 clear (32 KB switching), an address with CPU A14=0 maps to bank P and an address with A14=1 maps to bank P+1. P is program register bits 3:0 plus the outer offset O.
- R3: With control bit 3 set and control bit 2 set, an address with A14=0 maps to bank P and an address with A14=1 maps to bank 15+O.
- R4: With control bit 3 set and control bit 2 clear, an address with A14=0 maps to bank O and an address with A14=1 maps to bank P.
- R5: O is 16 when bit 4 of the low graphics register is set and 0 otherwise. Program register bit 4 never changes a program bank number.
- R6: With control bit 4 set (4 KB graphics), graphics A12=0 uses the low graphics register as the bank and A12=1 uses the high graphics register.
- R7: With control bit 4 clear (8 KB graphics), A12=0 uses the low graphics register with bit 0 cleared, and A12=1 uses that value plus 1.
- R8: `prg_phys_addr` is the bank number above CPU address bits 13:0. `gfx_phys_addr` is the bank number above graphics address bits 11:0.
- R9: Program bank numbers are reduced modulo PRG_BANKS (default 32). Graphics bank numbers are reduced modulo GFX_BANKS (default 16).
- R10: `ram_en` is 1 exactly when the CPU address lies in 0x6000–0x7FFF and program register bit 4 is 0.
- R11: Every output is registered and reflects the inputs of the previous rising clock edge. An active-low asynchronous reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_reg | input | 5 | Control: mirroring, program mode, graphics mode |
| gfx_lo_reg | input | 5 | Low graphics bank register; bit 4 is the outer program offset |
| gfx_hi_reg | input | 5 | High graphics bank register (4 KB mode) |
| prg_reg | input | 5 | Program bank in bits 3:0; bit 4 disables work RAM |
| cpu_addr | input | 16 | CPU address |
| gfx_addr | input | 13 | Graphics-bus address |
| prg_phys_addr | output | log2(PRG_BANKS)+14 (19) | Physical program ROM address |
| gfx_phys_addr | output | log2(GFX_BANKS)+12 (16) | Physical graphics ROM address |
| ram_en | output | 1 | Work RAM enable |
| mirror_mode | output | 2 | Mirroring code |

## Verification
Every result is due exactly one rising edge after its inputs change, because only one register stage lies between ports. The bench drives inputs on a falling edge and samples on the next falling edge, after exactly one rising edge. One directed case samples just before that edge and confirms that the old value still holds. Reset is checked both at start-up and when it is asserted in mid-run; in both cases the cleared outputs are checked without waiting for a clock edge. The checker properties use |=> and compare against $past of the inputs, so they check the same one-cycle relation.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    typedef enum logic [1:0] {
        MIR_ONE_A  = 2'd0,
        MIR_ONE_B  = 2'd1,
        MIR_VERT   = 2'd2,
        MIR_HORIZ  = 2'd3
    } mirror_e;

    // control register bit positions
    localparam int CTL_SLOT_LOW = 2;   // 16 KB mode: lower slot switchable
    localparam int CTL_PRG_16K  = 3;   // 16 KB program switching
    localparam int CTL_GFX_4K   = 4;   // two independent 4 KB graphics banks

    localparam int OUTER_BIT    = 4;   // in low graphics register
    localparam int RAM_OFF_BIT  = 4;   // in program register

    localparam int PRG_OFS_W    = 14;  // 16 KB page
    localparam int GFX_OFS_W    = 12;  // 4 KB page

endpackage

// File: rtl/mapper_prg_bank.sv
module mapper_prg_bank #(
    parameter  int BANKS = 32,
    localparam int BW    = $clog2(BANKS)
) (
    input  logic          split_mode,
    input  logic          low_switch,
    input  logic [3:0]    sel,
    input  logic          outer,
    input  logic          upper_half,
    output logic [BW-1:0] bank
);
    localparam int  RW   = 7;
    localparam bit  POW2 = (BANKS & (BANKS - 1)) == 0;

    logic [RW-1:0] base_d;
    logic [RW-1:0] raw_d;

    always_comb begin
        base_d = outer ? RW'(16) : '0;
        if (!split_mode) begin
            raw_d = base_d + RW'(sel) + RW'(upper_half);
        end else if (low_switch) begin
            raw_d = upper_half ? base_d + RW'(15) : base_d + RW'(sel);
        end else begin
            raw_d = upper_half ? base_d + RW'(sel) : base_d;
        end
    end

    generate
        if (POW2) begin : g_mask
            assign bank = BW'(raw_d);
        end else begin : g_mod
            assign bank = BW'(raw_d % RW'(BANKS));
        end
    endgenerate

endmodule

// File: rtl/mapper_gfx_bank.sv
module mapper_gfx_bank #(
    parameter  int BANKS = 16,
    localparam int BW    = $clog2(BANKS)
) (
    input  logic          four_k,
    input  logic [4:0]    lo_sel,
    input  logic [4:0]    hi_sel,
    input  logic          upper_half,
    output logic [BW-1:0] bank
);
    localparam int RW   = 6;
    localparam bit POW2 = (BANKS & (BANKS - 1)) == 0;

    logic [RW-1:0] raw_d;

    always_comb begin
        if (four_k) begin
            raw_d = upper_half ? RW'(hi_sel) : RW'(lo_sel);
        end else begin
            raw_d = RW'({lo_sel[4:1], 1'b0}) + RW'(upper_half);
        end
    end

    generate
        if (POW2) begin : g_mask
            assign bank = BW'(raw_d);
        end else begin : g_mod
            assign bank = BW'(raw_d % RW'(BANKS));
        end
    endgenerate

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import mapper_pkg::*;
#(
    parameter  int PRG_BANKS = 32,
    parameter  int GFX_BANKS = 16,
    localparam int PRG_BW    = $clog2(PRG_BANKS),
    localparam int GFX_BW    = $clog2(GFX_BANKS),
    localparam int PRG_AW    = PRG_BW + PRG_OFS_W,
    localparam int GFX_AW    = GFX_BW + GFX_OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        ctrl_reg,
    input  logic [4:0]        gfx_lo_reg,
    input  logic [4:0]        gfx_hi_reg,
    input  logic [4:0]        prg_reg,
    input  logic [15:0]       cpu_addr,
    input  logic [12:0]       gfx_addr,
    output logic [PRG_AW-1:0] prg_phys_addr,
    output logic [GFX_AW-1:0] gfx_phys_addr,
    output logic              ram_en,
    output logic [1:0]        mirror_mode
);

    typedef struct packed {
        logic [PRG_AW-1:0] prg_addr;
        logic [GFX_AW-1:0] gfx_addr;
        logic              ram_en;
        mirror_e           mir;
    } map_out_t;

    map_out_t          out_d, out_q;
    logic [PRG_BW-1:0] prg_bank_d;
    logic [GFX_BW-1:0] gfx_bank_d;

    mapper_prg_bank #(.BANKS(PRG_BANKS)) u_prg (
        .split_mode (ctrl_reg[CTL_PRG_16K]),
        .low_switch (ctrl_reg[CTL_SLOT_LOW]),
        .sel        (prg_reg[3:0]),
        .outer      (gfx_lo_reg[OUTER_BIT]),
        .upper_half (cpu_addr[PRG_OFS_W]),
        .bank       (prg_bank_d)
    );

    mapper_gfx_bank #(.BANKS(GFX_BANKS)) u_gfx (
        .four_k     (ctrl_reg[CTL_GFX_4K]),
        .lo_sel     (gfx_lo_reg),
        .hi_sel     (gfx_hi_reg),
        .upper_half (gfx_addr[GFX_OFS_W]),
        .bank       (gfx_bank_d)
    );

    always_comb begin
        out_d          = '0;
        out_d.prg_addr = {prg_bank_d, cpu_addr[PRG_OFS_W-1:0]};
        out_d.gfx_addr = {gfx_bank_d, gfx_addr[GFX_OFS_W-1:0]};
        out_d.ram_en   = (cpu_addr[15:13] == 3'b011) && !prg_reg[RAM_OFF_BIT];
        out_d.mir      = mirror_e'(ctrl_reg[1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign prg_phys_addr = out_q.prg_addr;
    assign gfx_phys_addr = out_q.gfx_addr;
    assign ram_en        = out_q.ram_en;
    assign mirror_mode   = out_q.mir;

endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
    parameter  int PRG_BANKS = 32,
    parameter  int GFX_BANKS = 16,
    localparam int PRG_BW    = $clog2(PRG_BANKS),
    localparam int GFX_BW    = $clog2(GFX_BANKS),
    localparam int PRG_AW    = PRG_BW + 14,
    localparam int GFX_AW    = GFX_BW + 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        ctrl_reg,
    input logic [4:0]        gfx_lo_reg,
    input logic [4:0]        gfx_hi_reg,
    input logic [4:0]        prg_reg,
    input logic [15:0]       cpu_addr,
    input logic [12:0]       gfx_addr,
    input logic [PRG_AW-1:0] prg_phys_addr,
    input logic [GFX_AW-1:0] gfx_phys_addr,
    input logic              ram_en,
    input logic [1:0]        mirror_mode
);
    logic [PRG_BW-1:0] fixed_top;
    logic [PRG_BW-1:0] switch_bank;
    logic [GFX_BW-1:0] hi_bank;

    assign fixed_top   = PRG_BW'((15 + (gfx_lo_reg[4] ? 16 : 0)) % PRG_BANKS);
    assign switch_bank = PRG_BW'((int'(prg_reg[3:0]) + (gfx_lo_reg[4] ? 16 : 0)) % PRG_BANKS);
    assign hi_bank     = GFX_BW'(int'(gfx_hi_reg) % GFX_BANKS);

    // R1
    mirror_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> mirror_mode == $past(ctrl_reg[1:0]));

    // R10
    ram_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ram_en == (($past(cpu_addr[15:13]) == 3'b011) && !$past(prg_reg[4])));

    // R8
    prg_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> prg_phys_addr[13:0] == $past(cpu_addr[13:0]));

    // R8
    gfx_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> gfx_phys_addr[11:0] == $past(gfx_addr[11:0]));

    // R3
    fixed_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_reg[3] && ctrl_reg[2] && cpu_addr[14]) |=> prg_phys_addr[PRG_AW-1:14] == $past(fixed_top));

    // R4
    switch_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_reg[3] && !ctrl_reg[2] && cpu_addr[14]) |=> prg_phys_addr[PRG_AW-1:14] == $past(switch_bank));

    // R6
    gfx_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_reg[4] && gfx_addr[12]) |=> gfx_phys_addr[GFX_AW-1:12] == $past(hi_bank));

    // R7
    gfx_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_reg[4] && !gfx_addr[12] && ((GFX_BANKS % 2) == 0)) |=> !gfx_phys_addr[12]);

endmodule

bind bank_mapper bank_mapper_chk #(.PRG_BANKS(PRG_BANKS), .GFX_BANKS(GFX_BANKS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_reg      (ctrl_reg),
    .gfx_lo_reg    (gfx_lo_reg),
    .gfx_hi_reg    (gfx_hi_reg),
    .prg_reg       (prg_reg),
    .cpu_addr      (cpu_addr),
    .gfx_addr      (gfx_addr),
    .prg_phys_addr (prg_phys_addr),
    .gfx_phys_addr (gfx_phys_addr),
    .ram_en        (ram_en),
    .mirror_mode   (mirror_mode)
);

// File: tb/sim_bank_mapper.sv
module sim_bank_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ctrl_reg = '0, gfx_lo_reg = '0, gfx_hi_reg = '0, prg_reg = '0;
    logic [15:0] cpu_addr = '0;
    logic [12:0] gfx_addr = '0;
    logic [18:0] prg_phys_addr;
    logic [15:0] gfx_phys_addr;
    logic        ram_en;
    logic [1:0]  mirror_mode;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    bank_mapper u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_reg(ctrl_reg), .gfx_lo_reg(gfx_lo_reg),
        .gfx_hi_reg(gfx_hi_reg), .prg_reg(prg_reg), .cpu_addr(cpu_addr),
        .gfx_addr(gfx_addr), .prg_phys_addr(prg_phys_addr),
        .gfx_phys_addr(gfx_phys_addr), .ram_en(ram_en), .mirror_mode(mirror_mode)
    );

    // {ctrl, glo, ghi, prg, cpu, gfx, exp prg bank, exp gfx bank, exp ram}
    localparam int N = 18;
    localparam logic [58:0] TBL [0:N-1] = '{
        {5'h0C, 5'h00, 5'h00, 5'h03, 16'h8123, 13'h0456, 5'd3,  4'd0,  1'b0},
        {5'h0C, 5'h00, 5'h00, 5'h03, 16'hC010, 13'h1ABC, 5'd15, 4'd1,  1'b0},
        {5'h08, 5'h07, 5'h00, 5'h05, 16'h8000, 13'h0000, 5'd0,  4'd6,  1'b0},
        {5'h08, 5'h07, 5'h00, 5'h05, 16'hFFFF, 13'h1FFF, 5'd5,  4'd7,  1'b0},
        {5'h01, 5'h00, 5'h00, 5'h06, 16'h8001, 13'h0100, 5'd6,  4'd0,  1'b0},
        {5'h01, 5'h00, 5'h00, 5'h06, 16'hC001, 13'h1100, 5'd7,  4'd1,  1'b0},
        {5'h0E, 5'h10, 5'h00, 5'h02, 16'h9000, 13'h0000, 5'd18, 4'd0,  1'b0},
        {5'h0E, 5'h10, 5'h00, 5'h02, 16'hE000, 13'h1000, 5'd31, 4'd1,  1'b0},
        {5'h1B, 5'h13, 5'h09, 5'h04, 16'h8000, 13'h0800, 5'd16, 4'd3,  1'b0},
        {5'h1B, 5'h13, 5'h09, 5'h04, 16'hC000, 13'h1800, 5'd20, 4'd9,  1'b0},
        {5'h10, 5'h1F, 5'h0F, 5'h0F, 16'hC555, 13'h0ABC, 5'd0,  4'd15, 1'b0},
        {5'h10, 5'h1F, 5'h0F, 5'h0F, 16'h8555, 13'h1ABC, 5'd31, 4'd15, 1'b0},
        {5'h0C, 5'h00, 5'h00, 5'h00, 16'h6000, 13'h0000, 5'd15, 4'd0,  1'b1},
        {5'h0C, 5'h00, 5'h00, 5'h00, 16'h7FFF, 13'h0000, 5'd15, 4'd0,  1'b1},
        {5'h0C, 5'h00, 5'h00, 5'h10, 16'h7FFF, 13'h0000, 5'd15, 4'd0,  1'b0},
        {5'h0C, 5'h00, 5'h00, 5'h00, 16'h5FFF, 13'h0000, 5'd15, 4'd0,  1'b0},
        {5'h0C, 5'h00, 5'h00, 5'h00, 16'h8000, 13'h0000, 5'd0,  4'd0,  1'b0},
        {5'h0C, 5'h00, 5'h00, 5'h13, 16'h8000, 13'h0000, 5'd3,  4'd0,  1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] c, input logic [4:0] gl, input logic [4:0] gh,
                         input logic [4:0] p, input logic [15:0] ca, input logic [12:0] ga);
        @(negedge clk);
        ctrl_reg = c; gfx_lo_reg = gl; gfx_hi_reg = gh; prg_reg = p;
        cpu_addr = ca; gfx_addr = ga;
    endtask

    task automatic apply(input logic [4:0] c, input logic [4:0] gl, input logic [4:0] gh,
                         input logic [4:0] p, input logic [15:0] ca, input logic [12:0] ga);
        drive(c, gl, gh, p, ca, ga);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        chk("R11 reset prg", 32'(prg_phys_addr), 32'h0);
        chk("R11 reset gfx", 32'(gfx_phys_addr), 32'h0);
        chk("R11 reset ram", 32'(ram_en), 32'h0);
        chk("R11 reset mirror", 32'(mirror_mode), 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < N; i++) begin
            logic [58:0] v;
            string       ptag, gtag;
            v = TBL[i];
            apply(v[58:54], v[53:49], v[48:44], v[43:39], v[38:23], v[22:10]);
            ptag = !v[58+0-55] ? "R2" : (v[56] ? "R3" : "R4");
            ptag = !v[57] ? "R2" : (v[56] ? "R3" : "R4");
            gtag = v[58] ? "R6" : "R7";
            chk($sformatf("%s R8 prg vec%0d", ptag, i), 32'(prg_phys_addr),
                32'({v[9:5], v[36:23]}));
            chk($sformatf("%s R8 gfx vec%0d", gtag, i), 32'(gfx_phys_addr),
                32'({v[4:1], v[21:10]}));
            chk($sformatf("R10 ram vec%0d", i), 32'(ram_en), 32'(v[0]));
            chk($sformatf("R1 mirror vec%0d", i), 32'(mirror_mode), 32'(v[55:54]));
        end

        // R5: outer offset adds 16, program register bit 4 ignored
        apply(5'h0C, 5'h10, 5'h00, 5'h13, 16'h8000, 13'h0000);
        chk("R5 outer prg", 32'(prg_phys_addr), 32'({5'd19, 14'h0}));
        // R9: 32 KB upper slot 15+16+1 wraps to 0; graphics 17 wraps to 1
        apply(5'h00, 5'h10, 5'h00, 5'h0F, 16'hC000, 13'h1000);
        chk("R9 prg wrap", 32'(prg_phys_addr), 32'({5'd0, 14'h0}));
        chk("R9 gfx wrap", 32'(gfx_phys_addr), 32'({4'd1, 12'h0}));

        // R11 latency: output holds until the next rising edge
        apply(5'h0C, 5'h00, 5'h00, 5'h00, 16'h8000, 13'h0000);
        drive(5'h0C, 5'h00, 5'h00, 5'h00, 16'h6000, 13'h0000);
        #1;
        chk("R11 before edge", 32'(ram_en), 32'h0);
        @(negedge clk);
        chk("R11 after edge", 32'(ram_en), 32'h1);

        // R11 asynchronous reset in mid-run
        apply(5'h1B, 5'h13, 5'h09, 5'h04, 16'hC000, 13'h1800);
        rst_n = 1'b0;
        #1;
        chk("R11 async prg", 32'(prg_phys_addr), 32'h0);
        chk("R11 async gfx", 32'(gfx_phys_addr), 32'h0);
        chk("R11 async mirror", 32'(mirror_mode), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule